// File: doc/BRIEF.md
# Exception Entry Controller

This block takes a processor core into an exception. Every clock it looks at two level-sensitive interrupt lines and five trap or event requests. The two interrupt lines are the normal interrupt and the fast interrupt. The five others are warm reset, data abort, fetch abort, undefined opcode and system call. The two interrupt lines can be masked by bits of the live status word. The traps cannot be masked. The block picks the winning request by a fixed priority. In one clock edge it does four things:
- stores the return address from the core into the link register banked for the target mode;
- stores the live status word into that mode's saved-status register;
- switches the mode field and sets the mask bits;
- loads a vector address and raises a one-cycle load strobe that tells the fetch unit to redirect.

The core owns return-address adjustment and the handler code. It changes the status word through a plain write port. A read port addresses the banked registers by mode code, so the handler, or a bench, can read back what was saved.

Status word layout, which the core's decoder depends on: bits [4:0] hold the mode, bit 5 is passed through unchanged, bit 6 masks the fast interrupt, bit 7 masks the normal interrupt, and bits [XLEN-1:8] are flags that the block keeps unchanged.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status word is 0x000000D3: supervisor mode 10011, both mask bits set, all other bits zero. The vector strobe is low and every banked link and saved-status register reads zero.
- R2: A normal interrupt request is taken when status bit 7 is clear. Taking it does the following:
  - writes the return address into the interrupt bank and the pre-entry status word into that bank's saved-status register;
  - sets the mode to 10010 and sets bit 7, leaving bit 6 as it was;
  - loads vector 0x18.
- R3: A fast interrupt request is taken when status bit 6 is clear. It saves into the fast bank, sets mode 10001, sets bits 7 and 6, and loads vector 0x1C.
- R4: A normal interrupt request is ignored while bit 7 is set, and a fast interrupt request is ignored while bit 6 is set. The status word and the vector strobe do not change.
- R5: When several requests are live, exactly one is taken. The order from high to low is: reset, data abort, fast interrupt, normal interrupt, fetch abort, undefined opcode, system call. Masked interrupts take no part.
- R6: The traps are taken whatever the mask bits hold. Each one sets bit 7 and goes to its own vector and mode:
  - reset: 0x00, mode 10011; it also sets bit 6;
  - undefined opcode: 0x04, mode 11011;
  - system call: 0x08, mode 10011;
  - fetch abort: 0x0C, mode 10111;
  - data abort: 0x10, mode 10111.
- R7: Requests are sampled as levels. A request that is dropped before it is accepted (for example, an interrupt held only while masked) is never taken later.
- R8: The vector strobe is high for exactly one cycle per entry, in the cycle after the accepting edge. No new request is accepted in that cycle.
- R9: A status write takes effect at the next edge. If a write arrives in the same cycle as an acceptance, the write is discarded. The masks and the saved status both use the status word from before the write.
- R10: Entry leaves status bits [XLEN-1:8] and bit 5 unchanged.
- R11: The bank read port returns the link and saved-status registers of the bank whose mode code is on the select input. It returns zero for a mode that has no bank, such as user 10000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_req | input | 1 | Warm reset event request |
| data_abort_req | input | 1 | Data access fault request |
| fast_req | input | 1 | Fast interrupt level |
| irq_req | input | 1 | Normal interrupt level |
| fetch_abort_req | input | 1 | Instruction fetch fault request |
| undef_req | input | 1 | Undefined opcode request |
| syscall_req | input | 1 | System call request |
| ret_pc | input | XLEN | Return address to save on entry |
| st_wr_en | input | 1 | Status write strobe from the core |
| st_wr_data | input | XLEN | Status write value |
| status_out | output | XLEN | Live status word |
| vec_load | output | 1 | One-cycle redirect strobe |
| vec_addr | output | XLEN | Vector address, valid with vec_load |
| bank_sel_mode | input | 5 | Mode code that selects the bank to read |
| bank_lr | output | XLEN | Banked link register of the selected bank |
| bank_saved_st | output | XLEN | Saved status of the selected bank |

## Verification
Two functions can fall in the same cycle:
- an exception acceptance and a status write by the core;
- two exception requests, for example both interrupt lines, or a trap together with an interrupt.

The bench drives a status write and a normal interrupt on the same edge. It then checks that the saved status holds the pre-write word, that the mode is the interrupt mode, and that the written value never appears. The vector table raises combined requests under several mask settings and judges the result by the vector, the mode and the bank contents. A directed fast interrupt inside an interrupt handler checks that a nested entry saves the handler's own status.

// File: rtl/exc_pkg.sv
// Package: shared encodings for the exception entry controller.
// Assumes the status word layout: [4:0] mode, [6] fast mask, [7] normal mask.
package exc_pkg;

    localparam int MODE_W     = 5;
    localparam int NUM_SRC    = 7;
    localparam int NUM_BANK   = 5;
    localparam int BANK_IDX_W = $clog2(NUM_BANK);
    localparam int ST_FMASK   = 6;
    localparam int ST_IMASK   = 7;

    localparam logic [MODE_W-1:0] MODE_USER  = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FAST  = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ   = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SUPER = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABORT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UNDEF = 5'b11011;

    typedef enum logic [2:0] {
        EXC_NONE, EXC_RESET, EXC_DABT, EXC_FAST,
        EXC_IRQ, EXC_FABT, EXC_UNDEF, EXC_SYSCALL
    } exc_kind_e;

    typedef enum logic {CTL_IDLE, CTL_ENTER} ctl_state_e;

    // Maps a priority slot (higher index wins) to its exception kind.
    function automatic exc_kind_e slot_kind(input int slot);
        case (slot)
            6:       return EXC_RESET;
            5:       return EXC_DABT;
            4:       return EXC_FAST;
            3:       return EXC_IRQ;
            2:       return EXC_FABT;
            1:       return EXC_UNDEF;
            default: return EXC_SYSCALL;
        endcase
    endfunction

    // Byte offset of each vector inside the table.
    function automatic logic [7:0] vec_offset(input exc_kind_e k);
        case (k)
            EXC_UNDEF:   return 8'h04;
            EXC_SYSCALL: return 8'h08;
            EXC_FABT:    return 8'h0C;
            EXC_DABT:    return 8'h10;
            EXC_IRQ:     return 8'h18;
            EXC_FAST:    return 8'h1C;
            default:     return 8'h00;
        endcase
    endfunction

    // Mode entered by each exception kind.
    function automatic logic [MODE_W-1:0] target_mode(input exc_kind_e k);
        case (k)
            EXC_FAST:          return MODE_FAST;
            EXC_IRQ:           return MODE_IRQ;
            EXC_DABT, EXC_FABT: return MODE_ABORT;
            EXC_UNDEF:         return MODE_UNDEF;
            default:           return MODE_SUPER;
        endcase
    endfunction

    // True when the kind also masks the fast interrupt.
    function automatic logic sets_fast_mask(input exc_kind_e k);
        return (k == EXC_FAST) || (k == EXC_RESET);
    endfunction

    // Bank index of a mode; valid flag low for modes without a bank.
    function automatic logic [BANK_IDX_W:0] bank_of_mode(input logic [MODE_W-1:0] m);
        case (m)
            MODE_FAST:  return {1'b1, 3'd0};
            MODE_IRQ:   return {1'b1, 3'd1};
            MODE_SUPER: return {1'b1, 3'd2};
            MODE_ABORT: return {1'b1, 3'd3};
            MODE_UNDEF: return {1'b1, 3'd4};
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
// Module: exc_arbiter
// Applies the interrupt masks and picks one winning request by fixed
// priority. Purely combinational; enable gates the whole decision.
module exc_arbiter
    import exc_pkg::*;
(
    input  logic      enable,
    input  logic      reset_req,
    input  logic      data_abort_req,
    input  logic      fast_req,
    input  logic      irq_req,
    input  logic      fetch_abort_req,
    input  logic      undef_req,
    input  logic      syscall_req,
    input  logic      fast_mask,
    input  logic      irq_mask,
    output exc_kind_e winner
);

    logic [NUM_SRC-1:0] live;

    // Masked request vector, highest priority in the top bit.
    always_comb begin
        live = {reset_req, data_abort_req, fast_req & ~fast_mask,
                irq_req & ~irq_mask, fetch_abort_req, undef_req, syscall_req};
    end

    // Walk upward so that the highest live slot overrides the rest.
    always_comb begin
        winner = EXC_NONE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (enable && live[i]) winner = slot_kind(i);
        end
    end

endmodule

// File: rtl/exc_bank.sv
// Module: exc_bank
// Banked link and saved-status registers, one pair per exception mode.
// Assumes at most one bank is written per cycle.
module exc_bank
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [BANK_IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]       wr_link,
    input  logic [XLEN-1:0]       wr_saved,
    input  logic                  rd_valid,
    input  logic [BANK_IDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]       rd_link,
    output logic [XLEN-1:0]       rd_saved
);

    logic [XLEN-1:0] link_q  [NUM_BANK];
    logic [XLEN-1:0] saved_q [NUM_BANK];

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        // Capture the entry pair when this bank is the target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                link_q[b]  <= '0;
                saved_q[b] <= '0;
            end else if (wr_en && (wr_idx == BANK_IDX_W'(b))) begin
                link_q[b]  <= wr_link;
                saved_q[b] <= wr_saved;
            end
        end
    end

    // Read mux; a mode without a bank reads as zero.
    always_comb begin
        rd_link  = '0;
        rd_saved = '0;
        if (rd_valid && (int'(rd_idx) < NUM_BANK)) begin
            rd_link  = link_q[rd_idx];
            rd_saved = saved_q[rd_idx];
        end
    end

endmodule

// File: rtl/exc_status.sv
// Module: exc_status
// Live status word. An entry overrides a core write in the same cycle.
// Entry changes only the mode field and the mask bits.
module exc_status
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enter,
    input  exc_kind_e       enter_kind,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] status
);

    localparam logic [XLEN-1:0] RESET_VAL =
        XLEN'({1'b1, 1'b1, 1'b0, MODE_SUPER});

    // Status update: reset, then entry, then a plain core write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= RESET_VAL;
        end else if (enter) begin
            status[MODE_W-1:0] <= target_mode(enter_kind);
            status[ST_IMASK]   <= 1'b1;
            if (sets_fast_mask(enter_kind)) status[ST_FMASK] <= 1'b1;
        end else if (wr_en) begin
            status <= wr_data;
        end
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
// Module: exc_entry_ctrl (top)
// Accepts one exception at a time, saves the return address and the status
// into the target bank, switches mode and issues a one-cycle vector strobe.
// Assumes ret_pc is already adjusted by the core for the return.
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_req,
    input  logic              data_abort_req,
    input  logic              fast_req,
    input  logic              irq_req,
    input  logic              fetch_abort_req,
    input  logic              undef_req,
    input  logic              syscall_req,
    input  logic [XLEN-1:0]   ret_pc,
    input  logic              st_wr_en,
    input  logic [XLEN-1:0]   st_wr_data,
    output logic [XLEN-1:0]   status_out,
    output logic              vec_load,
    output logic [XLEN-1:0]   vec_addr,
    input  logic [MODE_W-1:0] bank_sel_mode,
    output logic [XLEN-1:0]   bank_lr,
    output logic [XLEN-1:0]   bank_saved_st
);

    ctl_state_e            state_q;
    exc_kind_e             winner;
    logic                  accept;
    logic [BANK_IDX_W:0]   wr_map;
    logic [BANK_IDX_W:0]   rd_map;
    logic [XLEN-1:0]       status_q;

    exc_arbiter u_arb (
        .enable          (state_q == CTL_IDLE),
        .reset_req       (reset_req),
        .data_abort_req  (data_abort_req),
        .fast_req        (fast_req),
        .irq_req         (irq_req),
        .fetch_abort_req (fetch_abort_req),
        .undef_req       (undef_req),
        .syscall_req     (syscall_req),
        .fast_mask       (status_q[ST_FMASK]),
        .irq_mask        (status_q[ST_IMASK]),
        .winner          (winner)
    );

    // Acceptance and bank index decode of the winning request.
    always_comb begin
        accept = (winner != EXC_NONE);
        wr_map = bank_of_mode(target_mode(winner));
        rd_map = bank_of_mode(bank_sel_mode);
    end

    exc_bank #(.XLEN(XLEN)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept && wr_map[BANK_IDX_W]),
        .wr_idx   (wr_map[BANK_IDX_W-1:0]),
        .wr_link  (ret_pc),
        .wr_saved (status_q),
        .rd_valid (rd_map[BANK_IDX_W]),
        .rd_idx   (rd_map[BANK_IDX_W-1:0]),
        .rd_link  (bank_lr),
        .rd_saved (bank_saved_st)
    );

    exc_status #(.XLEN(XLEN)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter      (accept),
        .enter_kind (winner),
        .wr_en      (st_wr_en),
        .wr_data    (st_wr_data),
        .status     (status_q)
    );

    // Sequencer: one entry cycle after every acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= CTL_IDLE;
        else if (accept) state_q <= CTL_ENTER;
        else             state_q <= CTL_IDLE;
    end

    // Registered redirect strobe and vector address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_load <= 1'b0;
            vec_addr <= VEC_BASE;
        end else begin
            vec_load <= accept;
            if (accept) vec_addr <= VEC_BASE + XLEN'(vec_offset(winner));
        end
    end

    assign status_out = status_q;

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
// Module: exc_entry_ctrl_chk
// Port-level temporal checks for exc_entry_ctrl; attached by bind below.
module exc_entry_ctrl_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reset_req,
    input logic            data_abort_req,
    input logic            fast_req,
    input logic            irq_req,
    input logic            fetch_abort_req,
    input logic            undef_req,
    input logic            syscall_req,
    input logic            st_wr_en,
    input logic [XLEN-1:0] st_wr_data,
    input logic [XLEN-1:0] status_out,
    input logic            vec_load,
    input logic [XLEN-1:0] vec_addr
);

    logic any_req;
    logic traps;
    assign traps   = reset_req | data_abort_req | fetch_abort_req | undef_req | syscall_req;
    assign any_req = traps | fast_req | irq_req;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |=> !vec_load); // R8

    AST_IRQ_VEC_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_load && vec_addr == XLEN'(8'h18)) |-> (status_out[4:0] == 5'b10010)); // R2

    AST_FAST_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_load && vec_addr == XLEN'(8'h1C)) |-> (status_out[7] && status_out[6])); // R3

    AST_ENTRY_IMASK: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |-> status_out[7]); // R6

    AST_MASKED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && status_out[7] && !fast_req && !traps && !vec_load) |=> !vec_load); // R4

    AST_FAST_OVER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_req && irq_req && !status_out[6] && !reset_req && !data_abort_req && !vec_load)
        |=> (vec_load && vec_addr == XLEN'(8'h1C))); // R5

    AST_STATUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr_en && !any_req) |=> (status_out == $past(st_wr_data))); // R9

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.XLEN(XLEN)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reset_req       (reset_req),
    .data_abort_req  (data_abort_req),
    .fast_req        (fast_req),
    .irq_req         (irq_req),
    .fetch_abort_req (fetch_abort_req),
    .undef_req       (undef_req),
    .syscall_req     (syscall_req),
    .st_wr_en        (st_wr_en),
    .st_wr_data      (st_wr_data),
    .status_out      (status_out),
    .vec_load        (vec_load),
    .vec_addr        (vec_addr)
);

// File: tb/exc_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb_top;

    localparam int XLEN = 32;
    localparam logic [31:0] FLAGS = 32'hA5A5_A500;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reset_req = 0, data_abort_req = 0, fast_req = 0, irq_req = 0;
    logic            fetch_abort_req = 0, undef_req = 0, syscall_req = 0;
    logic [XLEN-1:0] ret_pc = '0;
    logic            st_wr_en = 0;
    logic [XLEN-1:0] st_wr_data = '0;
    logic [XLEN-1:0] status_out, vec_addr, bank_lr, bank_saved_st;
    logic            vec_load;
    logic [4:0]      bank_sel_mode = 5'b10000;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    exc_entry_ctrl #(.XLEN(XLEN)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .reset_req(reset_req), .data_abort_req(data_abort_req),
        .fast_req(fast_req), .irq_req(irq_req),
        .fetch_abort_req(fetch_abort_req), .undef_req(undef_req),
        .syscall_req(syscall_req), .ret_pc(ret_pc),
        .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
        .status_out(status_out), .vec_load(vec_load), .vec_addr(vec_addr),
        .bank_sel_mode(bank_sel_mode), .bank_lr(bank_lr), .bank_saved_st(bank_saved_st)
    );

    // req order: {reset, data abort, fast, irq, fetch abort, undef, syscall}
    typedef struct packed {
        logic [6:0] req;
        logic [7:0] st;
        logic       take;
        logic [7:0] vec;
        logic [4:0] mode;
        logic       f;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{7'b0001000, 8'h10, 1'b1, 8'h18, 5'b10010, 1'b0}, // R2 irq
        '{7'b0010000, 8'h10, 1'b1, 8'h1C, 5'b10001, 1'b1}, // R3 fast
        '{7'b0001000, 8'h90, 1'b0, 8'h00, 5'b10000, 1'b0}, // R4 irq masked
        '{7'b0010000, 8'h50, 1'b0, 8'h00, 5'b10000, 1'b1}, // R4 fast masked
        '{7'b0000001, 8'h10, 1'b1, 8'h08, 5'b10011, 1'b0}, // R6 syscall
        '{7'b0000010, 8'h10, 1'b1, 8'h04, 5'b11011, 1'b0}, // R6 undef
        '{7'b0000100, 8'h10, 1'b1, 8'h0C, 5'b10111, 1'b0}, // R6 fetch abort
        '{7'b0100000, 8'h10, 1'b1, 8'h10, 5'b10111, 1'b0}, // R6 data abort
        '{7'b1000000, 8'h10, 1'b1, 8'h00, 5'b10011, 1'b1}, // R6 reset
        '{7'b0011000, 8'h10, 1'b1, 8'h1C, 5'b10001, 1'b1}, // R5 fast over irq
        '{7'b0011000, 8'h50, 1'b1, 8'h18, 5'b10010, 1'b1}, // R5 masked fast drops out
        '{7'b0110000, 8'h10, 1'b1, 8'h10, 5'b10111, 1'b0}, // R5 dabt over fast
        '{7'b0001100, 8'h10, 1'b1, 8'h18, 5'b10010, 1'b0}, // R5 irq over fabt
        '{7'b0000110, 8'h10, 1'b1, 8'h0C, 5'b10111, 1'b0}, // R5 fabt over undef
        '{7'b0000011, 8'h10, 1'b1, 8'h04, 5'b11011, 1'b0}, // R5 undef over syscall
        '{7'b1111111, 8'h10, 1'b1, 8'h00, 5'b10011, 1'b1}, // R5 all live
        '{7'b0000001, 8'h90, 1'b1, 8'h08, 5'b10011, 1'b0}  // R6 trap ignores mask
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_req(input logic [6:0] r);
        {reset_req, data_abort_req, fast_req, irq_req,
         fetch_abort_req, undef_req, syscall_req} = r;
    endtask

    task automatic write_status(input logic [31:0] v);
        @(negedge clk);
        st_wr_en = 1'b1; st_wr_data = v;
        @(negedge clk);
        st_wr_en = 1'b0;
    endtask

    task automatic run_vec(input vec_t t, input int idx);
        logic [31:0] pre;
        logic [31:0] pc;
        pre = FLAGS | {24'h0, t.st};
        pc  = 32'h0000_4000 + 32'(idx) * 4;
        write_status(pre);
        check("R9 write", status_out, pre);
        drive_req(t.req); ret_pc = pc;
        @(negedge clk);
        drive_req('0);
        if (t.take) begin
            check("R5/R6 strobe", {31'b0, vec_load}, 32'd1);
            check("R5/R6 vector", vec_addr, {24'h0, t.vec});
            check("R5/R6 mode", {27'b0, status_out[4:0]}, {27'b0, t.mode});
            check("R6 imask", {31'b0, status_out[7]}, 32'd1);
            check("R3 fmask", {31'b0, status_out[6]}, {31'b0, t.f});
            check("R10 flags", {status_out[31:8], 3'b0, status_out[5], 4'b0},
                  {pre[31:8], 3'b0, pre[5], 4'b0});
            bank_sel_mode = t.mode;
            #0.1;
            check("R2/R11 link", bank_lr, pc);
            check("R2/R11 saved", bank_saved_st, pre);
        end else begin
            check("R4 no strobe", {31'b0, vec_load}, 32'd0);
            check("R4 status kept", status_out, pre);
        end
        @(negedge clk);
        check("R8 pulse", {31'b0, vec_load}, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 status", status_out, 32'h0000_00D3);
        check("R1 strobe", {31'b0, vec_load}, 32'd0);
        for (int m = 0; m < 32; m++) begin
            bank_sel_mode = 5'(m);
            #0.1;
            if (bank_lr != 0 || bank_saved_st != 0) check("R1 banks", bank_lr | bank_saved_st, 0);
        end
        n_checks++;

        for (int i = 0; i < NV; i++) run_vec(TBL[i], i);

        // R11 user mode has no bank
        bank_sel_mode = 5'b10000;
        #0.1;
        check("R11 user link", bank_lr, 32'h0);
        check("R11 user saved", bank_saved_st, 32'h0);

        // R7 request withdrawn while masked is never taken
        write_status(FLAGS | 32'h90);
        irq_req = 1'b1;
        pulses = 0;
        repeat (3) begin @(negedge clk); pulses += int'(vec_load); end
        irq_req = 1'b0;
        write_status(FLAGS | 32'h10);
        repeat (3) begin @(negedge clk); pulses += int'(vec_load); end
        check("R7 no entry", 32'(pulses), 32'd0);
        check("R7 status", status_out, FLAGS | 32'h10);

        // R8 trap held across the entry cycle gives one strobe
        syscall_req = 1'b1;
        pulses = 0;
        @(negedge clk); pulses += int'(vec_load);
        @(negedge clk); pulses += int'(vec_load);
        syscall_req = 1'b0;
        repeat (2) begin @(negedge clk); pulses += int'(vec_load); end
        check("R8 single strobe", 32'(pulses), 32'd1);

        // R9 write colliding with acceptance is discarded
        write_status(FLAGS | 32'h10);
        st_wr_en = 1'b1; st_wr_data = 32'h0000_00D3;
        irq_req = 1'b1; ret_pc = 32'h0000_8888;
        @(negedge clk);
        st_wr_en = 1'b0; irq_req = 1'b0;
        check("R9 collide status", status_out, FLAGS | 32'h92);
        bank_sel_mode = 5'b10010;
        #0.1;
        check("R9 collide saved", bank_saved_st, FLAGS | 32'h10);
        @(negedge clk);
        check("R9 write dropped", status_out, FLAGS | 32'h92);

        // R3 nested fast interrupt inside the irq handler
        fast_req = 1'b1; ret_pc = 32'h0000_9990;
        @(negedge clk);
        fast_req = 1'b0;
        check("R3 nested vec", vec_addr, 32'h1C);
        bank_sel_mode = 5'b10001;
        #0.1;
        check("R3 nested link", bank_lr, 32'h0000_9990);
        check("R3 nested saved", bank_saved_st, FLAGS | 32'h92);
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule